// File: doc/BRIEF.md
# Two-Level I/O Virtual Address Page Table Walker

This block turns a 32-bit I/O virtual address into a physical address by walking a two-level translation table held in memory. A client presents a virtual address and keeps the request raised. The walker first reads a directory entry at the table base plus a scaled top-index. If that entry is valid, it reads a leaf entry from the second-level table that the entry points to. It then returns one response pulse carrying the physical address and the page's 4-bit authority index, or a fault flag that names the level that failed.

Table entries are fetched through a plain read port that has one read outstanding at a time. The port raises a request with an address and waits for a data-valid strobe, which may come in the same cycle or any number of cycles later. For each level, the virtual address of the most recent fault is kept in a register of its own. Translation caching, permission enforcement and data forwarding are done elsewhere.

Top module: `iova_walker`

## Requirements
- R1: On acceptance the walker samples `ttb_base`, and the first read goes to `ttb_base + vaddr[31:20]*4`.
- R2: A directory entry is valid only when its bits 1:0 equal 2'b01. The codes 2'b00, 2'b10 and 2'b11 end the walk with `resp_fault_l1`=1 after exactly one memory read.
- R3: After a valid directory entry, the second read goes to `{entry[31:10],10'b0} + vaddr[19:12]*4`. Directory bits 9:2 have no effect.
- R4: A leaf entry is valid only when its bit 1 is set. Otherwise the walk ends with `resp_fault_l2`=1 after exactly two reads.
- R5: On success, `resp_paddr = {leaf[31:12], vaddr[11:0]}` and `resp_aci = leaf[7:4]`. Leaf bits 11:8, 3:2 and 0 have no effect. On any fault both fields are zero.
- R6: `resp_valid` is high for exactly one cycle per walk. At most one fault flag is set, and if both levels were ever flagged the level-2 flag wins.
- R7: `l1_err_vaddr` and `l2_err_vaddr` reset to zero. Each takes the request's virtual address only when a fault of its own level is reported, and otherwise holds its value.
- R8: `mem_req` stays high with `mem_addr` unchanged from the cycle it rises until `mem_rvalid` is seen. `mem_req` is low whenever `resp_valid` is high.
- R9: Only one walk is in flight. Changes to `req_vaddr` or `ttb_base` after acceptance do not alter the result.
- R10: During reset, `resp_valid`, `mem_req` and both fault flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ttb_base | input | 32 | Directory base address |
| req_valid | input | 1 | Translation request, held until the response pulse |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 32 | Translated physical address |
| resp_aci | output | 4 | Authority control index of the page |
| resp_fault_l1 | output | 1 | Directory entry was invalid |
| resp_fault_l2 | output | 1 | Leaf entry was invalid |
| l1_err_vaddr | output | 32 | Virtual address of the last level-1 fault |
| l2_err_vaddr | output | 32 | Virtual address of the last level-2 fault |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench covers every invalid directory code (00, 10 and 11), a leaf with only its reserved bit 0 set, entries with all reserved bits set, and the last index at both levels. A decoder that tested only bit 0 of the directory, or that let reserved bits leak into the frame or the index, would return a wrong address or a wrong fault kind. The bench counts reads per walk and records both read addresses, so a walker that kept fetching after a level-1 fault, or that scaled an index wrongly, shows up. It also uses read latencies from one to six cycles and changes the base and the address in the middle of a walk, which catches a walker that lets go of the memory request early or reads live inputs after acceptance.

// File: rtl/iova_walk_pkg.sv
package iova_walk_pkg;

    typedef enum logic [2:0] {
        WK_IDLE     = 3'd0,
        WK_FETCH_L1 = 3'd1,
        WK_FETCH_L2 = 3'd2,
        WK_DONE     = 3'd3,
        WK_FAULT    = 3'd4
    } walk_state_e;

    // Directory entry validity code (low bits of the entry)
    localparam int unsigned DIR_CODE_W     = 2;
    localparam int unsigned DIR_VALID_CODE = 1;

    // Leaf entry fields
    localparam int unsigned LEAF_VALID_BIT = 1;
    localparam int unsigned ACI_LSB        = 4;
    localparam int unsigned ACI_W          = 4;

endpackage

// File: rtl/iova_index_sel.sv
module iova_index_sel #(
    parameter int unsigned VA_W   = 32,
    parameter int unsigned L1_W   = 12,
    parameter int unsigned L2_W   = 8,
    parameter int unsigned ENT_SH = 2
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic            second_level,
    input  logic [VA_W-1:0] base,
    output logic [VA_W-1:0] rd_addr
);
    localparam int unsigned OFF_W = VA_W - L1_W - L2_W;
    localparam logic [VA_W-1:0] L2_MASK = VA_W'((64'd1 << L2_W) - 64'd1);

    logic [VA_W-1:0] top_idx;
    logic [VA_W-1:0] mid_idx;
    logic [VA_W-1:0] scaled;

    always_comb begin
        top_idx = vaddr >> (L2_W + OFF_W);
        mid_idx = (vaddr >> OFF_W) & L2_MASK;
        scaled  = (second_level ? mid_idx : top_idx) << ENT_SH;
        rd_addr = base + scaled;
    end

endmodule

// File: rtl/iova_entry_dec.sv
module iova_entry_dec
    import iova_walk_pkg::*;
#(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned PT_ALN_W = 10,
    parameter int unsigned OFF_W    = 12
) (
    input  logic [VA_W-1:0]  word,
    output logic             dir_ok,
    output logic [VA_W-1:0]  pt_base,
    output logic             leaf_ok,
    output logic [VA_W-1:0]  frame,
    output logic [ACI_W-1:0] aci
);
    localparam logic [VA_W-1:0] CODE_MASK  = VA_W'((64'd1 << DIR_CODE_W) - 64'd1);
    localparam logic [VA_W-1:0] PT_MASK    = ~VA_W'((64'd1 << PT_ALN_W) - 64'd1);
    localparam logic [VA_W-1:0] FRAME_MASK = ~VA_W'((64'd1 << OFF_W) - 64'd1);
    localparam logic [VA_W-1:0] ACI_MASK   = VA_W'(((64'd1 << ACI_W) - 64'd1) << ACI_LSB);
    localparam logic [VA_W-1:0] VBIT_MASK  = VA_W'(64'd1 << LEAF_VALID_BIT);

    logic [VA_W-1:0] aci_wide;

    always_comb begin
        dir_ok   = (word & CODE_MASK) == VA_W'(DIR_VALID_CODE);
        pt_base  = word & PT_MASK;
        leaf_ok  = (word & VBIT_MASK) != '0;
        frame    = word & FRAME_MASK;
        aci_wide = (word & ACI_MASK) >> ACI_LSB;
        aci      = aci_wide[ACI_W-1:0];
    end

endmodule

// File: rtl/iova_walk_ctrl.sv
module iova_walk_ctrl
    import iova_walk_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [VA_W-1:0]  ttb_base,
    input  logic             mem_rvalid,
    input  logic             ent_dir_ok,
    input  logic [VA_W-1:0]  ent_pt_base,
    input  logic             ent_leaf_ok,
    input  logic [VA_W-1:0]  ent_frame,
    input  logic [ACI_W-1:0] ent_aci,
    input  logic [VA_W-1:0]  mem_addr,
    output logic             mem_req,
    output logic             second_level,
    output logic [VA_W-1:0]  walk_vaddr,
    output logic [VA_W-1:0]  walk_base,
    output logic             resp_valid,
    output logic [VA_W-1:0]  resp_paddr,
    output logic [ACI_W-1:0] resp_aci,
    output logic             resp_fault_l1,
    output logic             resp_fault_l2,
    output logic [VA_W-1:0]  l1_err_vaddr,
    output logic [VA_W-1:0]  l2_err_vaddr
);
    localparam logic [VA_W-1:0] OFF_MASK = VA_W'((64'd1 << OFF_W) - 64'd1);

    typedef struct packed {
        walk_state_e     st;
        logic [VA_W-1:0] va;
        logic [VA_W-1:0] base;
        logic [VA_W-1:0] pa;
        logic [ACI_W-1:0] aci;
        logic            f1;
        logic            f2;
        logic [VA_W-1:0] e1;
        logic [VA_W-1:0] e2;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WK_IDLE: begin
                if (req_valid) begin
                    r_d.st   = WK_FETCH_L1;
                    r_d.va   = req_vaddr;
                    r_d.base = ttb_base;
                    r_d.pa   = '0;
                    r_d.aci  = '0;
                    r_d.f1   = 1'b0;
                    r_d.f2   = 1'b0;
                end
            end
            WK_FETCH_L1: begin
                if (mem_rvalid) begin
                    if (ent_dir_ok) begin
                        r_d.st   = WK_FETCH_L2;
                        r_d.base = ent_pt_base;
                    end else begin
                        r_d.st = WK_FAULT;
                        r_d.f1 = 1'b1;
                        r_d.e1 = r_q.va;
                    end
                end
            end
            WK_FETCH_L2: begin
                if (mem_rvalid) begin
                    if (ent_leaf_ok) begin
                        r_d.st  = WK_DONE;
                        r_d.pa  = ent_frame | (r_q.va & OFF_MASK);
                        r_d.aci = ent_aci;
                    end else begin
                        r_d.st = WK_FAULT;
                        r_d.f2 = 1'b1;
                        r_d.e2 = r_q.va;
                    end
                end
            end
            WK_DONE, WK_FAULT: r_d.st = WK_IDLE;
            default:           r_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: WK_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req       = (r_q.st == WK_FETCH_L1) || (r_q.st == WK_FETCH_L2);
        second_level  = (r_q.st == WK_FETCH_L2);
        walk_vaddr    = r_q.va;
        walk_base     = r_q.base;
        resp_valid    = (r_q.st == WK_DONE) || (r_q.st == WK_FAULT);
        resp_paddr    = r_q.pa;
        resp_aci      = r_q.aci;
        // level-2 indication has precedence over level-1
        resp_fault_l2 = resp_valid && r_q.f2;
        resp_fault_l1 = resp_valid && r_q.f1 && !r_q.f2;
        l1_err_vaddr  = r_q.e1;
        l2_err_vaddr  = r_q.e2;
    end

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R8
    mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !mem_req);

    // R6
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R6
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_fault_l1, resp_fault_l2}));

    // R7
    l1_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(l1_err_vaddr) |-> (resp_valid && resp_fault_l1));

    // R7
    l2_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(l2_err_vaddr) |-> (resp_valid && resp_fault_l2));

endmodule

// File: rtl/iova_walker.sv
module iova_walker
    import iova_walk_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned L1_W      = 12,
    parameter int unsigned L2_W      = 8,
    parameter int unsigned ENT_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] ttb_base,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            resp_valid,
    output logic [VA_W-1:0] resp_paddr,
    output logic [3:0]      resp_aci,
    output logic            resp_fault_l1,
    output logic            resp_fault_l2,
    output logic [VA_W-1:0] l1_err_vaddr,
    output logic [VA_W-1:0] l2_err_vaddr,
    output logic            mem_req,
    output logic [VA_W-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [VA_W-1:0] mem_rdata
);
    localparam int unsigned OFF_W    = VA_W - L1_W - L2_W;
    localparam int unsigned ENT_SH   = $clog2(ENT_BYTES);
    localparam int unsigned PT_ALN_W = L2_W + ENT_SH;

    logic             second_level;
    logic [VA_W-1:0]  walk_vaddr;
    logic [VA_W-1:0]  walk_base;
    logic             dir_ok;
    logic             leaf_ok;
    logic [VA_W-1:0]  pt_base;
    logic [VA_W-1:0]  frame;
    logic [ACI_W-1:0] aci;

    iova_index_sel #(
        .VA_W(VA_W), .L1_W(L1_W), .L2_W(L2_W), .ENT_SH(ENT_SH)
    ) u_idx (
        .vaddr        (walk_vaddr),
        .second_level (second_level),
        .base         (walk_base),
        .rd_addr      (mem_addr)
    );

    iova_entry_dec #(
        .VA_W(VA_W), .PT_ALN_W(PT_ALN_W), .OFF_W(OFF_W)
    ) u_dec (
        .word    (mem_rdata),
        .dir_ok  (dir_ok),
        .pt_base (pt_base),
        .leaf_ok (leaf_ok),
        .frame   (frame),
        .aci     (aci)
    );

    iova_walk_ctrl #(
        .VA_W(VA_W), .OFF_W(OFF_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .ttb_base      (ttb_base),
        .mem_rvalid    (mem_rvalid),
        .ent_dir_ok    (dir_ok),
        .ent_pt_base   (pt_base),
        .ent_leaf_ok   (leaf_ok),
        .ent_frame     (frame),
        .ent_aci       (aci),
        .mem_addr      (mem_addr),
        .mem_req       (mem_req),
        .second_level  (second_level),
        .walk_vaddr    (walk_vaddr),
        .walk_base     (walk_base),
        .resp_valid    (resp_valid),
        .resp_paddr    (resp_paddr),
        .resp_aci      (resp_aci),
        .resp_fault_l1 (resp_fault_l1),
        .resp_fault_l2 (resp_fault_l2),
        .l1_err_vaddr  (l1_err_vaddr),
        .l2_err_vaddr  (l2_err_vaddr)
    );

endmodule

// File: tb/sim_iova_walker.sv
`timescale 1ns/1ps
module sim_iova_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ttb_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        resp_valid, resp_fault_l1, resp_fault_l2, mem_req;
    logic [31:0] resp_paddr, l1_err_vaddr, l2_err_vaddr, mem_addr;
    logic [3:0]  resp_aci;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    iova_walker u0 (
        .clk(clk), .rst_n(rst_n), .ttb_base(ttb_base),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_aci(resp_aci),
        .resp_fault_l1(resp_fault_l1), .resp_fault_l2(resp_fault_l2),
        .l1_err_vaddr(l1_err_vaddr), .l2_err_vaddr(l2_err_vaddr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // memory image and read port model
    logic [31:0] mem_img [logic [31:0]];
    int          lat = 1;
    int          wait_cnt = 0;
    int          reads = 0;
    int          addr_moves = 0;
    logic [31:0] first_addr = '0;
    logic [31:0] last_addr = '0;
    logic [31:0] held_addr = '0;

    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            wait_cnt   = 0;
        end else if (mem_req) begin
            if (wait_cnt > 0 && mem_addr != held_addr) addr_moves++;
            held_addr = mem_addr;
            wait_cnt++;
            if (wait_cnt >= lat) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_img.exists(mem_addr) ? mem_img[mem_addr] : 32'h0;
                reads++;
                if (reads == 1) first_addr = mem_addr;
                last_addr = mem_addr;
                wait_cnt  = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // stimulus/expected vectors
    localparam int NV = 8;
    localparam logic [31:0] V_VA [NV] = '{32'h1234_5678, 32'h1230_0FFF, 32'hFFF0_0000, 32'h0010_0000,
                                          32'h0020_0000, 32'h0030_0ABC, 32'h1230_1000, 32'h123F_F00A};
    localparam logic [31:0] V_PA [NV] = '{32'hABCD_E678, 32'h0000_1FFF, 32'h8000_0000, 32'h0,
                                          32'h0, 32'h0, 32'h0, 32'h0FFF_F00A};
    localparam logic [3:0]  V_ACI [NV] = '{4'h4, 4'h7, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'hA};
    localparam logic        V_F1 [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic        V_F2 [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam int          V_RD [NV] = '{2, 2, 2, 1, 1, 1, 2, 2};
    localparam logic [31:0] V_A1 [NV] = '{32'h0010_048C, 32'h0010_048C, 32'h0010_3FFC, 32'h0010_0004,
                                          32'h0010_0008, 32'h0010_000C, 32'h0010_048C, 32'h0010_048C};
    localparam logic [31:0] V_A2 [NV] = '{32'h0020_0514, 32'h0020_0400, 32'h0030_0000, 32'h0010_0004,
                                          32'h0010_0008, 32'h0010_000C, 32'h0020_0404, 32'h0020_07FC};
    localparam logic [31:0] V_E1 [NV] = '{32'h0, 32'h0, 32'h0, 32'h0010_0000,
                                          32'h0020_0000, 32'h0030_0ABC, 32'h0030_0ABC, 32'h0030_0ABC};
    localparam logic [31:0] V_E2 [NV] = '{32'h0, 32'h0, 32'h0, 32'h0,
                                          32'h0, 32'h0, 32'h1230_1000, 32'h1230_1000};
    localparam int          V_LAT [NV] = '{1, 3, 2, 1, 4, 1, 2, 1};

    logic [31:0] got_pa, got_e1, got_e2;
    logic [3:0]  got_aci;
    logic        got_f1, got_f2;

    task automatic start_walk(input logic [31:0] va);
        @(negedge clk);
        reads      = 0;
        addr_moves = 0;
        req_vaddr  = va;
        req_valid  = 1'b1;
    endtask

    task automatic finish_walk();
        do @(negedge clk); while (!resp_valid);
        got_pa  = resp_paddr;
        got_aci = resp_aci;
        got_f1  = resp_fault_l1;
        got_f2  = resp_fault_l2;
        got_e1  = l1_err_vaddr;
        got_e2  = l2_err_vaddr;
        req_valid = 1'b0;
        @(negedge clk);
        chk(!resp_valid, "R6 resp pulse one cycle", 32'(resp_valid), 32'h0);
    endtask

    initial begin
        mem_img[32'h0010_048C] = 32'h0020_0401;
        mem_img[32'h0020_0514] = 32'hABCD_E042;
        mem_img[32'h0020_0400] = 32'h0000_1F7F;
        mem_img[32'h0010_3FFC] = 32'h0030_03FD;
        mem_img[32'h0030_0000] = 32'h8000_0002;
        mem_img[32'h0010_0004] = 32'h0040_0003;
        mem_img[32'h0010_0008] = 32'h0040_0002;
        mem_img[32'h0020_0404] = 32'hABCD_E0F1;
        mem_img[32'h0020_07FC] = 32'h0FFF_F0A2;

        // R10 reset state
        repeat (3) @(negedge clk);
        chk(!resp_valid, "R10 resp_valid in reset", 32'(resp_valid), 32'h0);
        chk(!mem_req, "R10 mem_req in reset", 32'(mem_req), 32'h0);
        chk(!resp_fault_l1 && !resp_fault_l2, "R10 fault flags in reset",
            32'({resp_fault_l1, resp_fault_l2}), 32'h0);
        chk(l1_err_vaddr == 0 && l2_err_vaddr == 0, "R7 error regs reset",
            l1_err_vaddr | l2_err_vaddr, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            lat = V_LAT[i];
            start_walk(V_VA[i]);
            finish_walk();
            chk(got_pa == V_PA[i], $sformatf("R5 paddr vec%0d", i), got_pa, V_PA[i]);
            chk(got_aci == V_ACI[i], $sformatf("R5 aci vec%0d", i), 32'(got_aci), 32'(V_ACI[i]));
            chk(got_f1 == V_F1[i], $sformatf("R2 fault_l1 vec%0d", i), 32'(got_f1), 32'(V_F1[i]));
            chk(got_f2 == V_F2[i], $sformatf("R4 fault_l2 vec%0d", i), 32'(got_f2), 32'(V_F2[i]));
            chk(reads == V_RD[i], $sformatf("R2 read count vec%0d", i), 32'(reads), 32'(V_RD[i]));
            chk(first_addr == V_A1[i], $sformatf("R1 first read addr vec%0d", i), first_addr, V_A1[i]);
            chk(last_addr == V_A2[i], $sformatf("R3 last read addr vec%0d", i), last_addr, V_A2[i]);
            chk(got_e1 == V_E1[i], $sformatf("R7 l1 err vec%0d", i), got_e1, V_E1[i]);
            chk(got_e2 == V_E2[i], $sformatf("R7 l2 err vec%0d", i), got_e2, V_E2[i]);
            chk(addr_moves == 0, $sformatf("R8 addr held vec%0d", i), 32'(addr_moves), 32'h0);
        end

        // R9: inputs change during a slow walk
        lat = 6;
        start_walk(32'h1234_5678);
        repeat (3) @(negedge clk);
        ttb_base  = 32'hDEAD_0000;
        req_vaddr = 32'h0020_0000;
        finish_walk();
        chk(got_pa == 32'hABCD_E678, "R9 paddr after input change", got_pa, 32'hABCD_E678);
        chk(!got_f1 && !got_f2, "R9 no fault after input change", 32'({got_f1, got_f2}), 32'h0);
        chk(first_addr == 32'h0010_048C, "R9 first addr kept", first_addr, 32'h0010_048C);
        chk(addr_moves == 0, "R8 addr held on long wait", 32'(addr_moves), 32'h0);
        ttb_base = 32'h0010_0000;

        // R8: idle port after completion
        repeat (2) @(negedge clk);
        chk(!mem_req, "R8 mem_req idle", 32'(mem_req), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule